// File: doc/BRIEF.md
# Three-Slot Conversion Threshold Detector

This block watches the stream of conversion results that a converter sequencer produces and compares each result against three independent threshold slots. Each slot picks one source channel, a direction (trip when the result is above, or when it is below, the level) and an assert level. It can optionally add a second release level, which makes the comparison hysteretic. A slot that trips sets a sticky status bit. Software clears that bit by writing a one to it.

The status bits, each masked by its own interrupt enable, are ORed into a single interrupt line. That line can be merged with the converter's other interrupt sources. Configuration arrives as simple register writes, each carrying a 4-bit address and a data word. Bits [3:2] of the address select the register kind and bits [1:0] select the slot (0, 1 or 2 for slots 1 to 3).

Top module: `thr_detect`

## Requirements
- R1: After reset all status bits, the interrupt line, every slot enable and every interrupt enable are zero, so results on any channel set no status.
- R2: Writes decode as follows. Kind 0 is slot configuration: channel in bits [CH_W-1:0], direction at bit CH_W (1 = above, 0 = below), dual mode at bit CH_W+1, detection enable at bit CH_W+2. Kind 1 is the assert level. Kind 2 is the release level. Kind 3 is control.
- R3: A slot evaluates only on a result strobe whose channel equals its channel field. A strobe for any other channel leaves its status and state unchanged.
- R4: In single mode with direction above, a matching result sets status exactly when it is strictly greater than the assert level.
- R5: In single mode with direction below, a matching result sets status exactly when it is strictly less than the assert level. Equality never trips.
- R6: While a slot's enable is clear it sets no status, and its hysteresis state returns to released.
- R7: In dual mode a slot sets status only when it enters the tripped state, which happens when the result passes the assert level in its direction. It stays tripped, setting no further status, until a result passes the release level the other way. For above that is strictly less than the release level; for below it is strictly greater.
- R8: A control write clears status bit k (slot k+1) where data bit k is 1 and leaves it where the bit is 0. A status set in the same cycle as its clear wins.
- R9: The interrupt output is high exactly when some status bit is set and its enable is set. The enables are held in control data bits [6:4], one per slot in slot order, and are rewritten by every control write.
- R10: A status bit and the interrupt are visible right after the clock edge that captures the tripping strobe or the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | Conversion result strobe |
| res_chan_i | input | CH_W | Channel of the result |
| res_data_i | input | DATA_W | Result value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address: [3:2] kind, [1:0] slot |
| wr_data_i | input | DATA_W | Register write data |
| status_o | output | 3 | Sticky status, bit k for slot k+1 |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Every result is due one edge after its stimulus. The status register captures a tripping strobe, or a clearing write, at the first rising edge. The interrupt is a gate on that register and the enable register, so it changes at the same edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass and samples on the following falling edge. The sweeps clear status after every sample, so each observation reflects one strobe only.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    K_CFG    = 2'd0,
    K_ASRT   = 2'd1,
    K_RLS    = 2'd2,
    K_CTL    = 2'd3
  } reg_kind_e;

  localparam int unsigned IE_LSB = 4;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
#(
  parameter int unsigned NSLOT  = 3,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CH_W-1:0]   chan_o [NSLOT],
  output logic [NSLOT-1:0]  dir_o,
  output logic [NSLOT-1:0]  dual_o,
  output logic [NSLOT-1:0]  en_o,
  output logic [DATA_W-1:0] asrt_o [NSLOT],
  output logic [DATA_W-1:0] rls_o  [NSLOT],
  output logic [NSLOT-1:0]  ie_o,
  output logic [NSLOT-1:0]  clr_o
);
  localparam int unsigned DIR_BIT  = CH_W;
  localparam int unsigned DUAL_BIT = CH_W + 1;
  localparam int unsigned EN_BIT   = CH_W + 2;

  reg_kind_e  kind;
  logic [1:0] slot_sel;

  assign kind     = reg_kind_e'(wr_addr_i[3:2]);
  assign slot_sel = wr_addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      dual_o <= '0;
      en_o   <= '0;
      ie_o   <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        chan_o[k] <= '0;
        asrt_o[k] <= '0;
        rls_o[k]  <= '0;
      end
    end else if (wr_en_i) begin
      if (kind == K_CTL) ie_o <= wr_data_i[IE_LSB +: NSLOT];
      for (int k = 0; k < NSLOT; k++) begin
        if (slot_sel == 2'(k)) begin
          case (kind)
            K_CFG: begin
              chan_o[k] <= wr_data_i[CH_W-1:0];
              dir_o[k]  <= wr_data_i[DIR_BIT];
              dual_o[k] <= wr_data_i[DUAL_BIT];
              en_o[k]   <= wr_data_i[EN_BIT];
            end
            K_ASRT:  asrt_o[k] <= wr_data_i;
            K_RLS:   rls_o[k]  <= wr_data_i;
            default: ;
          endcase
        end
      end
    end
  end

  assign clr_o = (wr_en_i && kind == K_CTL) ? wr_data_i[NSLOT-1:0] : '0;
endmodule

// File: rtl/thr_slot.sv
module thr_slot #(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   chan_sel_i,
  input  logic              dir_i,
  input  logic              dual_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] asrt_i,
  input  logic [DATA_W-1:0] rls_i,
  output logic              set_o
);
  logic hit, trip, release_c, active_q;

  assign hit       = valid_i && en_i && (chan_i == chan_sel_i);
  assign trip      = dir_i ? (data_i > asrt_i) : (data_i < asrt_i);
  assign release_c = dir_i ? (data_i < rls_i)  : (data_i > rls_i);

  // Tripped state: hysteresis in dual mode, follows the compare in single mode.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (!en_i)     active_q <= 1'b0;
    else if (hit) begin
      if (!dual_i)      active_q <= trip;
      else if (active_q) active_q <= !release_c;
      else              active_q <= trip;
    end
  end

  assign set_o = hit && trip && (!dual_i || !active_q);

  AST_DIS_IDLE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    !en_i |=> !active_q);                                 // R6
  AST_HIT_CHAN:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                    set_o |-> (valid_i && chan_i == chan_sel_i));         // R3
  AST_DUAL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (set_o && dual_i) |=> active_q);                      // R7
endmodule

// File: rtl/thr_detect.sv
module thr_detect #(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [CH_W-1:0]   res_chan_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [2:0]        status_o,
  output logic              irq_o
);
  localparam int unsigned NSLOT = 3;

  logic [CH_W-1:0]   chan   [NSLOT];
  logic [DATA_W-1:0] asrt   [NSLOT];
  logic [DATA_W-1:0] rls    [NSLOT];
  logic [NSLOT-1:0]  dir, dual, en, ie, clr, set_w, status_q;

  thr_regs #(.NSLOT(NSLOT), .CH_W(CH_W), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .chan_o   (chan),
    .dir_o    (dir),
    .dual_o   (dual),
    .en_o     (en),
    .asrt_o   (asrt),
    .rls_o    (rls),
    .ie_o     (ie),
    .clr_o    (clr)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    thr_slot #(.CH_W(CH_W), .DATA_W(DATA_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (res_valid_i),
      .chan_i    (res_chan_i),
      .data_i    (res_data_i),
      .chan_sel_i(chan[k]),
      .dir_i     (dir[k]),
      .dual_i    (dual[k]),
      .en_i      (en[k]),
      .asrt_i    (asrt[k]),
      .rls_i     (rls[k]),
      .set_o     (set_w[k])
    );

    // Set beats a simultaneous clear.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        status_q[k] <= 1'b0;
      else if (set_w[k])  status_q[k] <= 1'b1;
      else if (clr[k])    status_q[k] <= 1'b0;
    end

    AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
                      $fell(status_q[k]) |->
                      $past(wr_en_i && wr_addr_i[3:2] == 2'd3 && wr_data_i[k])); // R8
    AST_STS_SET:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                      set_w[k] |=> status_q[k]);                                 // R10
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ie);

  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
                 irq_o |-> (status_o != 3'b000));                                // R9
endmodule

// File: tb/thr_detect_bench.sv
module thr_detect_bench;
  localparam int CH_W   = 3;
  localparam int DATA_W = 10;
  localparam int DMAX   = (1 << DATA_W) - 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              res_valid = 1'b0;
  logic [CH_W-1:0]   res_chan = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic              wr_en = 1'b0;
  logic [3:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [2:0]        status;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;
  int ie_cur  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  thr_detect #(.CH_W(CH_W), .DATA_W(DATA_W)) u_thr_detect (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .res_valid_i(res_valid),
    .res_chan_i (res_chan),
    .res_data_i (res_data),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .status_o   (status),
    .irq_o      (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cfgw(input int ch, input int above, input int dual, input int en);
    return ch | (above << CH_W) | (dual << (CH_W + 1)) | (en << (CH_W + 2));
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input int clr_bits);
    wr(12, clr_bits | (ie_cur << 4));
  endtask

  task automatic strobe(input int ch, input int d);
    @(negedge clk);
    res_valid = 1'b1; res_chan = CH_W'(ch); res_data = DATA_W'(d);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state, nothing trips while slots are disabled
    check("R1 status", int'(status), 0);
    check("R1 irq", int'(irq), 0);
    for (int c = 0; c < (1 << CH_W); c++) begin
      strobe(c, DMAX); strobe(c, 0);
    end
    check("R1 no trip", int'(status), 0);

    // R4/R10: slot 1 above, single
    wr(0, cfgw(2, 1, 0, 1)); wr(4, 500);
    for (int d = 0; d <= DMAX; d++) begin
      strobe(2, d);
      check("R4 R10 above", int'(status), (d > 500) ? 1 : 0);
      ctl(7);
    end

    // R5/R2: slot 3 below, single
    wr(2, cfgw(7, 0, 0, 1)); wr(6, 300);
    for (int d = 0; d <= DMAX; d++) begin
      strobe(7, d);
      check("R5 R2 below", int'(status), (d < 300) ? 4 : 0);
      ctl(7);
    end

    // R3: other channels leave slot 1 alone
    for (int c = 0; c < (1 << CH_W); c++) begin
      if (c != 2) begin
        strobe(c, DMAX);
        check("R3 channel", int'(status), 0);
      end
    end

    // R6: disabled slot does not trip
    wr(0, cfgw(2, 1, 0, 0));
    strobe(2, DMAX);
    check("R6 disabled", int'(status), 0);

    // R7: slot 2 dual, above, assert 600 release 400
    begin
      bit act = 0;
      int exp;
      wr(1, cfgw(5, 1, 1, 1)); wr(5, 600); wr(9, 400);
      for (int i = 0; i < 400; i++) begin
        int d = (i * 211 + 17) % (DMAX + 1);
        exp = 0;
        if (!act && d > 600) begin act = 1; exp = 2; end
        else if (act && d < 400) act = 0;
        strobe(5, d);
        check("R7 dual above", int'(status), exp);
        ctl(7);
      end
      // R6: disable releases the hysteresis state
      wr(1, cfgw(5, 0, 1, 0));
      wr(5, 300); wr(9, 500);
      wr(1, cfgw(5, 0, 1, 1));
      act = 0;
      for (int i = 0; i < 400; i++) begin
        int d = (i * 157 + 91) % (DMAX + 1);
        exp = 0;
        if (!act && d < 300) begin act = 1; exp = 2; end
        else if (act && d > 500) act = 0;
        strobe(5, d);
        check("R7 dual below", int'(status), exp);
        ctl(7);
      end
      // R6: tripped, disable and re-enable, trips again at once
      strobe(5, 10); ctl(7);
      wr(1, cfgw(5, 0, 1, 0)); wr(1, cfgw(5, 0, 1, 1));
      strobe(5, 10);
      check("R6 state released", int'(status), 2);
      ctl(7);
    end

    // R8: write-one-to-clear and set-over-clear
    wr(0, cfgw(2, 1, 0, 1));
    strobe(2, 900); strobe(7, 10);
    check("R8 setup", int'(status), 5);
    ctl(4);
    check("R8 clear bit2", int'(status), 1);
    ctl(0);
    check("R8 zero keeps", int'(status), 1);
    ctl(1);
    check("R8 clear bit0", int'(status), 0);
    @(negedge clk);
    res_valid = 1'b1; res_chan = 3'd2; res_data = 10'd900;
    wr_en = 1'b1; wr_addr = 4'd12; wr_data = 10'd1;
    @(negedge clk);
    res_valid = 1'b0; wr_en = 1'b0;
    check("R8 set wins", int'(status), 1);

    // R9: interrupt masking
    ie_cur = 2; ctl(0);
    check("R9 masked", int'(irq), 0);
    ie_cur = 1; ctl(0);
    check("R9 enabled", int'(irq), 1);
    ie_cur = 7; ctl(0);
    check("R9 all", int'(irq), 1);
    ctl(1);
    check("R9 cleared", int'(irq), 0);
    strobe(7, 0);
    check("R9 R10 slot3 irq", int'(irq), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule